// File: doc/BRIEF.md
# ROM entry list walker

This block walks the chain of variable-length records stored after the fixed header of a configuration ROM image. The image sits in a byte-addressable buffer outside the block, reached through a one-byte read port with one cycle of read latency. After a start pulse the walker reads each record's length byte and descriptor byte. Port records are decoded into an internal per-port table, and any port slot can be looked up through a combinational select port. Generic records carrying the vendor or device name are reported as string windows, each a start address and a byte count. The walker does not copy the strings.

The bounds rules are strict. A zero length, a record that runs past the image size, or a record start on the last byte of the image counts as an overrun. The first overrun in a walk does not end it. The walker waits a programmable number of cycles, pulses a re-read request, waits for the acknowledge and then walks the image again from the start. A second overrun ends the walk with an error code. An enabled port record with the wrong length ends the walk at once, with no retry.

Top module: `rom_walker`

## Requirements
- R1: A walk begins at byte address `HDR_BYTES` (22 by default). At each step the position grows by that record's length byte. The walk ends with `done`=1 and `err`=0 once the position is at or above `rom_size`. An image of exactly `HDR_BYTES` bytes finishes with no records read.
- R2: Byte 0 of a record is its total length, which includes the two header bytes. In byte 1, bits 5:0 hold the index, bit 6 holds the port-disabled flag and bit 7 holds the type (1 = port record, 0 = generic record).
- R3: An overrun is a length byte of 0, a position plus length greater than `rom_size`, or a position equal to `rom_size`-1. An overrun that occurs after the retry has been used ends the walk with `err`=1.
- R4: The first overrun of a walk starts a wait of at least `RETRY_WAIT` cycles. A one-cycle `reread_req` pulse follows, and the walker then waits for `reread_ack`. It then restarts from `HDR_BYTES`. Each start produces at most one `reread_req`.
- R5: A port record whose index is greater than `max_port` is skipped without error, whatever its length.
- R6: A disabled port record sets only the disabled flag of its table slot. Its link, dual-link flag and partner fields read 0.
- R7: An enabled port record in range must be exactly 8 bytes long. Any other length ends the walk with `err`=2 and no `reread_req`.
- R8: For an enabled port record, byte 2 bit 4 is stored as the link number and byte 2 bit 7 as the has-dual-link flag. Byte 3 bits 5:0 are stored as the partner port only when the flag is set; otherwise the partner reads 0.
- R9: A generic record with index 1 sets the vendor window and one with index 2 sets the device window. Each window's address is the record position plus 2 and its length is the record length minus 2. Generic records with any other index change nothing.
- R10: The port table and both string windows are cleared at every walk start, including the restart after a re-read.
- R11: `mem_rd` is asserted only for addresses below `rom_size`. The byte appears on `mem_data` in the following cycle.
- R12: `busy` stays high from the accepted start until the walk ends. `done` and `err` hold until the next start. A start pulse while `busy` is high is ignored. After reset `busy`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted while idle) |
| rom_size | input | AW | Total image size in bytes, held stable during a walk |
| max_port | input | 6 | Highest port index that has a table slot in use |
| mem_rd | output | 1 | Buffer read strobe |
| mem_addr | output | AW | Buffer read address |
| mem_data | input | 8 | Buffer read data, one cycle after the strobe |
| reread_req | output | 1 | One-cycle request to reload the image buffer |
| reread_ack | input | 1 | Reload finished |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, held until next start |
| err | output | 2 | 0 ok, 1 overrun, 2 bad port record length |
| vend_valid | output | 1 | Vendor-name window found |
| vend_pos | output | AW | Vendor-name first byte address |
| vend_len | output | 8 | Vendor-name byte count |
| dev_valid | output | 1 | Device-name window found |
| dev_pos | output | AW | Device-name first byte address |
| dev_len | output | 8 | Device-name byte count |
| tbl_sel | input | 6 | Port table slot to look up |
| tbl_disabled | output | 1 | Selected slot: port disabled |
| tbl_link | output | 1 | Selected slot: link number |
| tbl_has_dual | output | 1 | Selected slot: has dual-link partner |
| tbl_partner | output | 6 | Selected slot: partner port number |

## Verification
The assertions check, on every cycle, that reads never touch an address at or past the image size, that `reread_req` is a single-cycle pulse issued at most once per start, that `done` and `busy` never overlap, and that a nonzero error code appears only with `done`. The decoded content can only be shown by the bench's scenarios: table fields, window positions and lengths, skipping of out-of-range ports, the strict port length, and the clearing of the table between walks. The same holds for the outcome of a retry, which depends on whether the reloaded image is repaired. A sweep over every index from 0 to 15 checks the index range and the field bits of port records.

// File: rtl/rom_walk_pkg.sv
package rom_walk_pkg;
    localparam int IDX_W    = 6;
    localparam int TYPE_BIT = 7;
    localparam int DIS_BIT  = 6;
    localparam int LINK_BIT = 4;
    localparam int DUAL_BIT = 7;

    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_LEN, S_HDR, S_DEC, S_B2, S_B3, S_WAIT, S_REQ, S_ACK
    } walk_state_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_OVERRUN  = 2'd1,
        ERR_PORT_LEN = 2'd2
    } walk_err_e;

    typedef struct packed {
        logic             dis;
        logic             link;
        logic             dual;
        logic [IDX_W-1:0] partner;
    } port_rec_t;
endpackage

// File: rtl/rom_entry_decode.sv
module rom_entry_decode
    import rom_walk_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [AW-1:0]    pos,
    input  logic [AW-1:0]    size,
    input  logic [7:0]       len,
    input  logic [7:0]       desc,
    output logic             bad,
    output logic             is_port,
    output logic             disabled,
    output logic [IDX_W-1:0] idx
);
    logic [AW:0] end_pos;

    always_comb begin
        end_pos  = {1'b0, pos} + {{(AW-7){1'b0}}, len};
        bad      = (len == 8'd0) || (end_pos > {1'b0, size});
        is_port  = desc[TYPE_BIT];
        disabled = desc[DIS_BIT];
        idx      = desc[IDX_W-1:0];
    end
endmodule

// File: rtl/rom_port_table.sv
module rom_port_table
    import rom_walk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  port_rec_t        wrec,
    input  logic [IDX_W-1:0] ridx,
    output port_rec_t        rrec
);
    localparam int NUM = 1 << IDX_W;

    port_rec_t slot_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                slot_q[g] <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                slot_q[g] <= wrec;
            end
        end
    end

    assign rrec = slot_q[ridx];
endmodule

// File: rtl/rom_retry_timer.sv
module rom_retry_timer #(
    parameter int WAIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(WAIT + 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(WAIT);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0) && !load;
endmodule

// File: rtl/rom_walker.sv
module rom_walker
    import rom_walk_pkg::*;
#(
    parameter int AW           = 12,
    parameter int HDR_BYTES    = 22,
    parameter int PORT_REC_LEN = 8,
    parameter int RETRY_WAIT   = 10000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    rom_size,
    input  logic [5:0]       max_port,
    output logic             mem_rd,
    output logic [AW-1:0]    mem_addr,
    input  logic [7:0]       mem_data,
    output logic             reread_req,
    input  logic             reread_ack,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err,
    output logic             vend_valid,
    output logic [AW-1:0]    vend_pos,
    output logic [7:0]       vend_len,
    output logic             dev_valid,
    output logic [AW-1:0]    dev_pos,
    output logic [7:0]       dev_len,
    input  logic [5:0]       tbl_sel,
    output logic             tbl_disabled,
    output logic             tbl_link,
    output logic             tbl_has_dual,
    output logic [5:0]       tbl_partner
);
    localparam logic [AW-1:0] START_POS = AW'(HDR_BYTES);
    localparam logic [7:0]    PLEN      = 8'(PORT_REC_LEN);

    typedef struct packed {
        walk_state_e      state;
        logic [AW-1:0]    pos;
        logic [7:0]       len;
        logic [IDX_W-1:0] idx;
        logic             link;
        logic             dual;
        logic             retry_used;
        logic             done;
        walk_err_e        err;
        logic             vend_valid;
        logic [AW-1:0]    vend_pos;
        logic [7:0]       vend_len;
        logic             dev_valid;
        logic [AW-1:0]    dev_pos;
        logic [7:0]       dev_len;
    } walk_regs_t;

    walk_regs_t q, n;

    logic             dec_bad, dec_port, dec_dis;
    logic [IDX_W-1:0] dec_idx;
    logic             tbl_clr, tbl_we, tmr_load, tmr_expired;
    port_rec_t        wrec, rrec;
    logic [AW:0]      next_pos;

    rom_entry_decode #(.AW(AW)) u_dec (
        .pos      (q.pos),
        .size     (rom_size),
        .len      (q.len),
        .desc     (mem_data),
        .bad      (dec_bad),
        .is_port  (dec_port),
        .disabled (dec_dis),
        .idx      (dec_idx)
    );

    rom_port_table u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tbl_clr),
        .we    (tbl_we),
        .widx  (q.state == S_B3 ? q.idx : dec_idx),
        .wrec  (wrec),
        .ridx  (tbl_sel),
        .rrec  (rrec)
    );

    rom_retry_timer #(.WAIT(RETRY_WAIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    always_comb begin
        n          = q;
        tbl_clr    = 1'b0;
        tbl_we     = 1'b0;
        wrec       = '0;
        tmr_load   = 1'b0;
        mem_rd     = 1'b0;
        mem_addr   = q.pos;
        reread_req = 1'b0;
        next_pos   = {1'b0, q.pos} + {{(AW-7){1'b0}}, q.len};

        case (q.state)
            S_IDLE: begin
                if (start) begin
                    n.state      = S_CHECK;
                    n.retry_used = 1'b0;
                    n.done       = 1'b0;
                    n.err        = ERR_NONE;
                end
            end
            S_CHECK: begin
                if (q.pos >= rom_size) begin
                    n.state = S_IDLE;
                    n.done  = 1'b1;
                end else if (q.pos == rom_size - 1'b1) begin
                    n.state = S_WAIT;
                end else begin
                    n.state = S_LEN;
                end
            end
            S_LEN: begin
                mem_rd  = 1'b1;
                n.state = S_HDR;
            end
            S_HDR: begin
                n.len    = mem_data;
                mem_rd   = 1'b1;
                mem_addr = q.pos + AW'(1);
                n.state  = S_DEC;
            end
            S_DEC: begin
                n.state = S_CHECK;
                n.pos   = next_pos[AW-1:0];
                if (dec_bad) begin
                    n.pos   = q.pos;
                    n.state = S_WAIT;
                end else if (dec_port) begin
                    if (dec_idx > max_port) begin
                        n.state = S_CHECK;
                    end else if (dec_dis) begin
                        tbl_we   = 1'b1;
                        wrec.dis = 1'b1;
                    end else if (q.len != PLEN) begin
                        n.pos   = q.pos;
                        n.state = S_IDLE;
                        n.done  = 1'b1;
                        n.err   = ERR_PORT_LEN;
                    end else begin
                        n.pos    = q.pos;
                        n.idx    = dec_idx;
                        mem_rd   = 1'b1;
                        mem_addr = q.pos + AW'(2);
                        n.state  = S_B2;
                    end
                end else if (dec_idx == IDX_W'(1)) begin
                    n.vend_valid = 1'b1;
                    n.vend_pos   = q.pos + AW'(2);
                    n.vend_len   = q.len - 8'd2;
                end else if (dec_idx == IDX_W'(2)) begin
                    n.dev_valid  = 1'b1;
                    n.dev_pos    = q.pos + AW'(2);
                    n.dev_len    = q.len - 8'd2;
                end
            end
            S_B2: begin
                n.link   = mem_data[LINK_BIT];
                n.dual   = mem_data[DUAL_BIT];
                mem_rd   = 1'b1;
                mem_addr = q.pos + AW'(3);
                n.state  = S_B3;
            end
            S_B3: begin
                tbl_we       = 1'b1;
                wrec.link    = q.link;
                wrec.dual    = q.dual;
                wrec.partner = q.dual ? mem_data[IDX_W-1:0] : '0;
                n.pos        = next_pos[AW-1:0];
                n.state      = S_CHECK;
            end
            S_WAIT: begin
                if (tmr_expired) n.state = S_REQ;
            end
            S_REQ: begin
                reread_req = 1'b1;
                n.state    = S_ACK;
            end
            S_ACK: begin
                if (reread_ack) n.state = S_CHECK;
            end
            default: n.state = S_IDLE;
        endcase

        // Overrun entry: spend the single retry or give up.
        if (n.state == S_WAIT && q.state != S_WAIT) begin
            if (q.retry_used) begin
                n.state = S_IDLE;
                n.done  = 1'b1;
                n.err   = ERR_OVERRUN;
            end else begin
                n.retry_used = 1'b1;
                tmr_load     = 1'b1;
            end
        end

        // Every walk pass, first or retried, begins from a clean slate.
        if ((q.state == S_IDLE && start) || (q.state == S_ACK && reread_ack)) begin
            tbl_clr      = 1'b1;
            n.pos        = START_POS;
            n.vend_valid = 1'b0;
            n.vend_pos   = '0;
            n.vend_len   = '0;
            n.dev_valid  = 1'b0;
            n.dev_pos    = '0;
            n.dev_len    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.err   <= ERR_NONE;
        end else begin
            q <= n;
        end
    end

    assign busy         = (q.state != S_IDLE);
    assign done         = q.done;
    assign err          = q.err;
    assign vend_valid   = q.vend_valid;
    assign vend_pos     = q.vend_pos;
    assign vend_len     = q.vend_len;
    assign dev_valid    = q.dev_valid;
    assign dev_pos      = q.dev_pos;
    assign dev_len      = q.dev_len;
    assign tbl_disabled = rrec.dis;
    assign tbl_link     = rrec.link;
    assign tbl_has_dual = rrec.dual;
    assign tbl_partner  = rrec.partner;
endmodule

// File: rtl/rom_walker_chk.sv
module rom_walker_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [1:0]    err,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] rom_size,
    input logic          reread_req
);
    logic [1:0] req_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_cnt_q <= '0;
        end else if (start && !busy) begin
            req_cnt_q <= '0;
        end else if (reread_req && req_cnt_q != 2'd3) begin
            req_cnt_q <= req_cnt_q + 1'b1;
        end
    end

    a_r11_read_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr < rom_size));

    a_r4_single_reread: assert property (@(posedge clk) disable iff (!rst_n)
        reread_req |-> (req_cnt_q == 2'd0));

    a_r4_req_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reread_req |=> !reread_req);

    a_r12_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r12_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    a_r7_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (err != 2'd0) |-> done);
endmodule

bind rom_walker rom_walker_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .rom_size   (rom_size),
    .reread_req (reread_req)
);

// File: tb/rom_walker_test.sv
module rom_walker_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 12;
    localparam int WAITC      = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] rom_size = '0;
    logic [5:0]    max_port = 6'd7;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_q = 8'd0;
    logic          reread_req;
    logic          reread_ack = 1'b0;
    logic          busy, done;
    logic [1:0]    err;
    logic          vend_valid, dev_valid;
    logic [AW-1:0] vend_pos, dev_pos;
    logic [7:0]    vend_len, dev_len;
    logic [5:0]    tbl_sel = '0;
    logic          tbl_disabled, tbl_link, tbl_has_dual;
    logic [5:0]    tbl_partner;

    logic [7:0] mem [256];
    int nchk = 0;
    int nfail = 0;
    int rereads = 0;
    bit fix_on_retry = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr[7:0]];

    rom_walker #(.AW(AW), .RETRY_WAIT(WAITC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rom_size(rom_size),
        .max_port(max_port), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_data(mem_q), .reread_req(reread_req), .reread_ack(reread_ack),
        .busy(busy), .done(done), .err(err),
        .vend_valid(vend_valid), .vend_pos(vend_pos), .vend_len(vend_len),
        .dev_valid(dev_valid), .dev_pos(dev_pos), .dev_len(dev_len),
        .tbl_sel(tbl_sel), .tbl_disabled(tbl_disabled), .tbl_link(tbl_link),
        .tbl_has_dual(tbl_has_dual), .tbl_partner(tbl_partner)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    endtask

    task automatic wipe();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic put(input int a, input int b0, input int b1, input int b2, input int b3);
        mem[a] = 8'(b0); mem[a+1] = 8'(b1); mem[a+2] = 8'(b2); mem[a+3] = 8'(b3);
    endtask

    task automatic walk(input int size);
        rom_size = AW'(size);
        rereads  = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int t = 0; t < 3000 && !done; t++) @(negedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R12 walk timeout actual=%0d expected=1", done);
        end
    endtask

    task automatic port_chk(input string tag, input int idx, input int dis,
                            input int link, input int dual, input int part);
        tbl_sel = 6'(idx);
        #1;
        chk(tag, {tbl_disabled, tbl_link, tbl_has_dual, tbl_partner},
            (dis << 8) | (link << 7) | (dual << 6) | part);
    endtask

    // Reload responder: counts requests, optionally repairs the image.
    initial begin
        forever begin
            @(negedge clk);
            if (reread_req) begin
                rereads++;
                if (fix_on_retry) begin
                    put(22, 8, 8'h83, 8'h80, 8'h04);
                end
                repeat (2) @(negedge clk);
                reread_ack = 1'b1;
                @(negedge clk);
                reread_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        wipe();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset busy", busy, 0);
        chk("R12 reset done", done, 0);
        chk("R12 reset err", err, 0);

        // R1: header-only image finishes with no records
        walk(22);
        chk("R1 empty err", err, 0);
        chk("R1 empty no window", vend_valid, 0);

        // Mixed image, max_port = 7
        wipe();
        put(22, 6, 8'h01, 65, 66); put(26, 67, 68, 0, 0);
        put(28, 5, 8'h02, 88, 89); mem[32] = 90;
        put(33, 3, 8'h03, 0, 0);
        put(36, 8, 8'h81, 8'h90, 8'h02); put(40, 0, 0, 0, 0);
        put(44, 8, 8'h82, 8'h10, 8'h3F); put(48, 0, 0, 0, 0);
        put(52, 2, 8'hC5, 0, 0);
        put(54, 3, 8'h89, 0, 0);
        walk(57);
        chk("R1 mixed err", err, 0);
        chk("R5 oversize idx skipped no reread", rereads, 0);
        chk("R9 vendor valid", vend_valid, 1);
        chk("R9 vendor pos", vend_pos, 24);
        chk("R9 vendor len", vend_len, 4);
        chk("R9 device valid", dev_valid, 1);
        chk("R9 device pos", dev_pos, 30);
        chk("R9 device len", dev_len, 3);
        port_chk("R8 port1 link dual partner", 1, 0, 1, 1, 2);
        port_chk("R8 port2 no dual partner zero", 2, 0, 1, 0, 0);
        port_chk("R6 port5 disabled only", 5, 1, 0, 0, 0);
        port_chk("R2 generic idx3 no table write", 3, 0, 0, 0, 0);
        port_chk("R5 port9 skipped", 9, 0, 0, 0, 0);

        // R10: new walk clears table and windows
        walk(22);
        chk("R10 vendor cleared", vend_valid, 0);
        chk("R10 device cleared", dev_valid, 0);
        port_chk("R10 port1 cleared", 1, 0, 0, 0, 0);

        // R4: zero length, repaired on reload
        wipe();
        mem[22] = 0; mem[23] = 8'h83;
        fix_on_retry = 1'b1;
        walk(30);
        fix_on_retry = 1'b0;
        chk("R4 retry success err", err, 0);
        chk("R4 one reread", rereads, 1);
        port_chk("R4 port3 after retry", 3, 0, 0, 1, 4);

        // R3/R4: persistent zero length
        wipe();
        mem[22] = 0;
        walk(30);
        chk("R3 zero len err", err, 1);
        chk("R4 still one reread", rereads, 1);

        // R3: position lands on size-1
        wipe();
        put(22, 2, 8'h00, 0, 0);
        walk(25);
        chk("R3 last byte err", err, 1);

        // R3: record extends past size; exact fit is fine
        wipe();
        put(22, 6, 8'h05, 0, 0);
        walk(26);
        chk("R3 past size err", err, 1);
        walk(28);
        chk("R3 exact fit err", err, 0);

        // R7: enabled port record of wrong length
        wipe();
        put(22, 7, 8'h81, 8'h10, 0);
        walk(29);
        chk("R7 bad port len err", err, 2);
        chk("R7 no reread", rereads, 0);
        // R6: the same record disabled is accepted
        mem[23] = 8'hC1;
        walk(29);
        chk("R6 disabled ignores length", err, 0);
        port_chk("R6 disabled slot", 1, 1, 0, 0, 0);

        // R5/R8 sweep over indexes 0..15
        for (int i = 0; i < 16; i++) begin
            int b2, b3, inr;
            wipe();
            b2 = (i[0] ? 8'h10 : 0) | (i[1] ? 8'h80 : 0) | 8'h2F;
            b3 = (i + 40) | 8'hC0;
            put(22, 8, 8'h80 | i, b2, b3);
            walk(30);
            inr = (i <= 7) ? 1 : 0;
            chk("R5 sweep err", err, 0);
            port_chk("R8 sweep slot", i, 0, inr & int'(i[0]), inr & int'(i[1]),
                     (inr & int'(i[1])) ? ((i + 40) & 63) : 0);
        end

        summary();
        $finish;
    end
endmodule